// File: doc/BRIEF.md
# SDRAM Refresh Request Scheduler

This block decides when an SDRAM array needs an auto-refresh and runs the refresh burst once the command arbiter agrees. A prescaler divides the clock into ticks. An interval counter counts those ticks and raises a refresh request once per row-refresh period. For an array that needs 4096 rows every 64 ms, that period is 15.625 us. Expiries that arrive while a request is still waiting are counted, so a late grant does not lose a refresh.

When the arbiter grants the request, the block strobes one auto-refresh command to each attached device in turn, one device per clock. After the last strobe it holds a busy indication for a programmable recovery window. The arbiter uses busy to keep back activates, reads and writes. Software keeps refresh switched off through memory initialization and switches it on as the last step. Switching it off clears the interval timer and any waiting refreshes, but a burst that has already started still completes.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ref_req`, `ref_busy` and every bit of `ref_strobe` are 0.
- R2: While `refresh_en` is 0, `ref_req` stays 0, and a high `ref_gnt` starts no burst: `ref_strobe` and `ref_busy` stay 0.
- R3: With divider value D on `tick_div` and interval value N on `interval_ticks`, a tick occurs every D+1 clocks and an interval lasts N+1 ticks. `ref_req` first rises (N+1)*(D+1)+1 clock edges after the edge that first samples `refresh_en` high. Later expiries follow every (N+1)*(D+1) edges.
- R4: `ref_req` stays high until it is sampled together with `ref_gnt`, and it is low after that same edge. A `ref_gnt` that is sampled while `ref_req` is low is ignored.
- R5: The edge that accepts a grant makes `ref_strobe` equal to 1 (bit 0, device 0). Each following edge moves the single set bit up by one position, until bit NUM_DEV-1 has been high for one cycle. At most one strobe bit is ever high.
- R6: After the last strobe, `ref_busy` stays high for exactly C+2 more cycles, where C is the value of `recov_code`. The code 5 gives 7 cycles. In total, busy is high for NUM_DEV+C+2 cycles per burst.
- R7: `ref_req` is never high while `ref_busy` is high. Refreshes that come due during a burst are requested once busy falls.
- R8: Up to 3 interval expiries that arrive without a grant are remembered, and each one later produces its own request and burst. Any further expiries are dropped.
- R9: Taking `refresh_en` low clears the interval timer and all remembered refreshes at once. A burst that has already started still runs its full strobe and recovery sequence. Once `refresh_en` is high again, the first request needs a full new interval, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refresh_en | input | 1 | Turns refresh generation on |
| tick_div | input | PRESC_W | Prescaler value D; one tick every D+1 clocks |
| interval_ticks | input | TIMER_W | Interval value N; one expiry every N+1 ticks |
| recov_code | input | REC_W | Recovery code C; C+2 recovery clocks |
| ref_req | output | 1 | Refresh request to the command arbiter |
| ref_gnt | input | 1 | Grant from the command arbiter |
| ref_strobe | output | NUM_DEV | One auto-refresh strobe for each device |
| ref_busy | output | 1 | High from grant until recovery ends; blocks other commands |

## Verification
The hardest situation to reach is a backlog of waiting refreshes. Several expiries must build up with no grant, and the backlog must then be drained after the timer has been slowed down, so that new expiries do not blur the count. The bench lets five short intervals pass with the grant held low. It then raises the divider and the interval to their largest values and grants every request it sees. Exactly three bursts must follow. A second run lets only two expiries build up and expects two bursts. A burst that is interrupted by a disable is reached by dropping `refresh_en` in the cycle right after the grant is accepted.

// File: rtl/sref_pkg.sv
`timescale 1ns/1ps
package sref_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_BURST = 2'd1,
    SQ_RECOV = 2'd2
  } seq_state_t;

  // recovery clocks for a given code: code + 2 (code 5 -> 7 clocks)
  function automatic int recov_cycles(input int code);
    return code + 2;
  endfunction

endpackage

// File: rtl/sref_prescaler.sv
`timescale 1ns/1ps
module sref_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [PRESC_W-1:0] div,
  output logic               tick
);

  logic [PRESC_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R9: a disabled prescaler emits no tick
  a_r9_no_tick_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick);

endmodule

// File: rtl/sref_interval.sv
`timescale 1ns/1ps
module sref_interval #(
  parameter int TIMER_W = 8,
  parameter int PEND_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               tick,
  input  logic [TIMER_W-1:0] interval,
  input  logic               accept,
  output logic [PEND_W-1:0]  pend,
  output logic [PEND_W-1:0]  pend_nxt
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [TIMER_W-1:0] tcnt;
  logic               expire;

  assign expire = en && tick && (tcnt >= interval);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      tcnt <= '0;
    end else if (tick) begin
      if (tcnt >= interval) tcnt <= '0;
      else                  tcnt <= tcnt + 1'b1;
    end
  end

  always_comb begin
    pend_nxt = pend;
    if (!en) begin
      pend_nxt = '0;
    end else if (expire && !accept) begin
      if (pend != PEND_MAX) pend_nxt = pend + 1'b1;
    end else if (!expire && accept) begin
      if (pend != '0) pend_nxt = pend - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend_nxt;
  end

  // R9: disabling clears the backlog on the next edge
  a_r9_pend_clear: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pend == '0));

  // R8: a full backlog is held, not wrapped, while no grant arrives
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (en && pend == PEND_MAX && !accept) |=> (pend == PEND_MAX));

  // R4: a grant is only accepted with something pending
  a_r4_accept_pending: assert property (@(posedge clk) disable iff (rst)
    accept |-> (pend != '0));

endmodule

// File: rtl/sref_burst_seq.sv
`timescale 1ns/1ps
module sref_burst_seq
  import sref_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int REC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [REC_W-1:0]   rec_code,
  output logic [NUM_DEV-1:0] strobe,
  output logic               busy,
  output logic               busy_nxt
);

  localparam int RC_MAX = (1 << REC_W) + 1;
  localparam int RC_W   = $clog2(RC_MAX + 1);

  seq_state_t         st, st_n;
  logic [NUM_DEV-1:0] str_n;
  logic [RC_W-1:0]    rcnt, rc_n;

  always_comb begin
    st_n  = st;
    str_n = strobe;
    rc_n  = rcnt;
    unique case (st)
      SQ_IDLE: begin
        if (accept) begin
          st_n  = SQ_BURST;
          str_n = NUM_DEV'(1);
        end
      end
      SQ_BURST: begin
        if (strobe[NUM_DEV-1]) begin
          st_n  = SQ_RECOV;
          str_n = '0;
          rc_n  = RC_W'(recov_cycles(int'(rec_code)));
        end else begin
          str_n = strobe << 1;
        end
      end
      SQ_RECOV: begin
        if (rcnt <= RC_W'(1)) st_n = SQ_IDLE;
        else                  rc_n = rcnt - 1'b1;
      end
      default: begin
        st_n  = SQ_IDLE;
        str_n = '0;
      end
    endcase
    busy_nxt = (st_n != SQ_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_IDLE;
      strobe <= '0;
      rcnt   <= '0;
      busy   <= 1'b0;
    end else begin
      st     <= st_n;
      strobe <= str_n;
      rcnt   <= rc_n;
      busy   <= busy_nxt;
    end
  end

  // R5: never more than one device strobed in a cycle
  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

  // R5: strobes only appear inside a busy window
  a_r5_strobe_in_busy: assert property (@(posedge clk) disable iff (rst)
    (strobe != '0) |-> busy);

  // R6: busy never ends directly after a strobe (recovery always follows)
  a_r6_recovery_tail: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(strobe) == '0));

endmodule

// File: rtl/sdram_refresh_sched.sv
`timescale 1ns/1ps
module sdram_refresh_sched #(
  parameter int NUM_DEV = 4,
  parameter int PRESC_W = 8,
  parameter int TIMER_W = 8,
  parameter int REC_W   = 3,
  parameter int PEND_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               refresh_en,
  input  logic [PRESC_W-1:0] tick_div,
  input  logic [TIMER_W-1:0] interval_ticks,
  input  logic [REC_W-1:0]   recov_code,
  output logic               ref_req,
  input  logic               ref_gnt,
  output logic [NUM_DEV-1:0] ref_strobe,
  output logic               ref_busy
);

  logic              tick;
  logic              accept;
  logic              busy_nxt;
  logic [PEND_W-1:0] pend;
  logic [PEND_W-1:0] pend_nxt;
  logic              req_q;

  assign accept  = ref_gnt && req_q;
  assign ref_req = req_q;

  sref_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .en   (refresh_en),
    .div  (tick_div),
    .tick (tick)
  );

  sref_interval #(.TIMER_W(TIMER_W), .PEND_W(PEND_W)) u_intv (
    .clk      (clk),
    .rst      (rst),
    .en       (refresh_en),
    .tick     (tick),
    .interval (interval_ticks),
    .accept   (accept),
    .pend     (pend),
    .pend_nxt (pend_nxt)
  );

  sref_burst_seq #(.NUM_DEV(NUM_DEV), .REC_W(REC_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .rec_code (recov_code),
    .strobe   (ref_strobe),
    .busy     (ref_busy),
    .busy_nxt (busy_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= (pend_nxt != '0) && !busy_nxt;
  end

  // R7: no request while the burst or recovery is running
  a_r7_no_req_busy: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> !ref_busy);

  // R4: an unanswered request is held while refresh stays enabled
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_gnt && refresh_en) |=> ref_req);

  // R4/R5: an accepted grant drops the request and strobes device 0
  a_r5_burst_start: assert property (@(posedge clk) disable iff (rst)
    (ref_req && ref_gnt) |=> (!ref_req && ref_strobe[0] && ref_busy));

  // R2: nothing starts without a pending request
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!ref_busy && !(ref_req && ref_gnt)) |=> !ref_busy);

  // R8: the request mirrors the backlog whenever the sequencer is idle
  a_r8_req_tracks: assert property (@(posedge clk) disable iff (rst)
    (!ref_busy && pend != '0) |-> ref_req);

endmodule

// File: tb/test_sdram_refresh_sched.sv
`timescale 1ns/1ps
module test_sdram_refresh_sched;

  localparam int NUM_DEV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       refresh_en = 1'b0;
  logic [7:0] tick_div = '0;
  logic [7:0] interval_ticks = '0;
  logic [2:0] recov_code = 3'd5;
  logic       ref_gnt = 1'b0;
  logic       ref_req;
  logic [NUM_DEV-1:0] ref_strobe;
  logic       ref_busy;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sdram_refresh_sched #(.NUM_DEV(NUM_DEV)) i_sdram_refresh_sched (
    .clk            (clk),
    .rst            (rst),
    .refresh_en     (refresh_en),
    .tick_div       (tick_div),
    .interval_ticks (interval_ticks),
    .recov_code     (recov_code),
    .ref_req        (ref_req),
    .ref_gnt        (ref_gnt),
    .ref_strobe     (ref_strobe),
    .ref_busy       (ref_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; refresh_en = 1'b0; ref_gnt = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // counts edges from enable until ref_req is seen high
  task automatic wait_req(output int edges);
    edges = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (ref_req) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!ref_req && !ref_busy && ref_strobe == 0, "R1 outputs in reset",
        int'({ref_req, ref_busy, ref_strobe}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!ref_req && !ref_busy && ref_strobe == 0, "R1 outputs after reset",
        int'({ref_req, ref_busy, ref_strobe}), 0);
  endtask

  task automatic t_disabled();
    int bad;
    do_reset();
    tick_div = 0; interval_ticks = 1; ref_gnt = 1'b1; bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ref_req || ref_busy || ref_strobe != 0) bad++;
    end
    ref_gnt = 1'b0;
    chk(bad == 0, "R2 disabled: no request, grant ignored", bad, 0);
  endtask

  task automatic t_latency();
    int e; int bad;
    do_reset();
    tick_div = 3; interval_ticks = 4;
    refresh_en = 1'b1;
    wait_req(e);
    chk(e == 21, "R3 first request latency", e, 21);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!ref_req || ref_busy) bad++;
    end
    chk(bad == 0, "R4 request held without grant", bad, 0);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk(!ref_req, "R4 request drops on grant", ref_req, 0);
    chk(ref_strobe == 1 && ref_busy, "R5 device 0 strobed after grant",
        int'(ref_strobe), 1);
  endtask

  task automatic t_period();
    int e;
    do_reset();
    tick_div = 0; interval_ticks = 19; recov_code = 5;
    refresh_en = 1'b1;
    wait_req(e);
    chk(e == 21, "R3 latency with no prescale", e, 21);
    ref_gnt = 1'b1;
    @(posedge clk); e = 1;
    @(negedge clk); ref_gnt = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (ref_req) break;
      @(posedge clk); e++;
      @(negedge clk);
    end
    chk(e == 20, "R3 request period", e, 20);
  endtask

  task automatic t_burst(input int code);
    int e; int busy_len; int bad; int rq;
    do_reset();
    tick_div = 0; interval_ticks = 29; recov_code = 3'(code);
    refresh_en = 1'b1;
    wait_req(e);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    bad = 0; busy_len = 0; rq = 0;
    for (int k = 0; k < 20; k++) begin
      if (!ref_busy) break;
      busy_len++;
      if (ref_req) rq++;
      if (k < NUM_DEV) begin
        if (ref_strobe != (NUM_DEV'(1) << k)) bad++;
      end else if (ref_strobe != 0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R5 strobe order one per clock", bad, 0);
    chk(busy_len == NUM_DEV + code + 2, "R6 busy window length", busy_len,
        NUM_DEV + code + 2);
    chk(rq == 0, "R7 no request during busy", rq, 0);
  endtask

  task automatic t_backlog(input int wait_cyc, input int exp_bursts, input string tag);
    int grants;
    do_reset();
    tick_div = 0; interval_ticks = 9; recov_code = 0;
    refresh_en = 1'b1;
    repeat (wait_cyc) @(negedge clk);
    tick_div = 8'hFF; interval_ticks = 8'hFF;
    grants = 0;
    for (int i = 0; i < 120; i++) begin
      ref_gnt = ref_req;
      if (ref_req) grants++;
      @(negedge clk);
    end
    ref_gnt = 1'b0;
    chk(grants == exp_bursts, tag, grants, exp_bursts);
  endtask

  task automatic t_disable_mid();
    int e; int busy_len; logic [NUM_DEV-1:0] seen; int rq;
    do_reset();
    tick_div = 0; interval_ticks = 4; recov_code = 5;
    refresh_en = 1'b1;
    wait_req(e);
    repeat (12) @(negedge clk);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0; refresh_en = 1'b0;
    busy_len = 0; seen = '0; rq = 0;
    for (int k = 0; k < 30; k++) begin
      if (!ref_busy) break;
      busy_len++; seen |= ref_strobe;
      if (ref_req) rq++;
      @(negedge clk);
    end
    chk(busy_len == NUM_DEV + 7 && seen == '1, "R9 burst completes after disable",
        busy_len, NUM_DEV + 7);
    repeat (10) @(negedge clk);
    chk(!ref_req && rq == 0, "R9 backlog cleared by disable", int'(ref_req) + rq, 0);
    tick_div = 0; interval_ticks = 29;
    refresh_en = 1'b1;
    wait_req(e);
    chk(e == 31, "R9 fresh interval after re-enable", e, 31);
    refresh_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_latency();
    t_period();
    t_burst(5);
    t_burst(0);
    t_burst(7);
    t_backlog(25, 2, "R8 two expiries give two bursts");
    t_backlog(60, 3, "R8 backlog saturates at three");
    t_disable_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule